// File: doc/BRIEF.md
# Return-Direction Four-Port Register Datapath

This block carries data from a pair of 9-bit wide-side buses (called X and Y) back to four narrow-side ports, numbered 0 to 3. Each port owns a storage register clocked by the return clock. Each register has its own load enable. A word-mode control picks where the registers load from. In narrow mode all four take X. In wide mode the even ports (0 and 2) take X and the odd ports (1 and 3) take Y, so the two buses act as one 18-bit word that is split across port pairs.

Each port value is chosen by a shared 2-bit path select from three sources. The first is the port's forward-direction capture register, which comes in as an input to this block; this is the readback path. The second is the port's own return register. The third is a pass-through of X and Y. The outputs carry values only. Output drive enables and control synchronization are handled elsewhere. The registers can capture X/Y data while the pass-through is selected.

Top module: `xa_route_top`

## Requirements
- R1: A synchronous active-high reset clears all four return registers to zero on the next rising clock edge.
- R2: A return register takes its source on a rising edge only when its load enable is 1, and holds its value when its enable is 0.
- R3: With word_mode = 0, every return register that loads takes the value of x_in.
- R4: With word_mode = 1, ports 0 and 2 load from x_in and ports 1 and 3 load from y_in.
- R5: The load enables are independent: ld_en bit p affects only port p's register.
- R6: path_sel = 2'b00 drives each port with its own forward capture value (ir_flat bits [p*9 +: 9]) in the same cycle.
- R7: path_sel = 2'b01 drives each port with its own return register.
- R8: path_sel = 2'b10 drives x_in to all four ports, whatever word_mode is.
- R9: path_sel = 2'b11 drives x_in to ports 0 and 2 and y_in to ports 1 and 3, whatever word_mode is.
- R10: While a pass-through select (2'b10 or 2'b11) is active, the return registers still load as R2 to R5 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Return-direction register clock |
| rst | input | 1 | Synchronous active-high reset |
| x_in | input | 9 | Wide-side bus X |
| y_in | input | 9 | Wide-side bus Y |
| ir_flat | input | 36 | Forward capture values; port p in bits [p*9 +: 9] |
| ld_en | input | 4 | Per-port return register load enable |
| word_mode | input | 1 | 0: all registers load from X; 1: even from X, odd from Y |
| path_sel | input | 2 | 00 readback, 01 return register, 10 X to all, 11 X even / Y odd |
| port_out | output | 36 | Port values; port p in bits [p*9 +: 9] |

## Verification
A register load becomes visible one rising edge after its enable is applied. The path-select multiplexer has no register, so its results appear in the same cycle. The bench changes inputs on the falling edge and clocks a load through one rising edge. It then checks the return registers at the following falling edge through path_sel = 01. Each multiplexer case is checked 1 ns after the select or its data changes, always before the next rising edge, so no load can move a value during a check.

// File: rtl/xa_route_pkg.sv
`timescale 1ns/1ps
package xa_route_pkg;
  typedef enum logic [1:0] {
    SEL_READBACK = 2'b00,
    SEL_HELD     = 2'b01,
    SEL_BCAST    = 2'b10,
    SEL_SPLIT    = 2'b11
  } path_sel_e;
endpackage

// File: rtl/xa_src_pick.sv
`timescale 1ns/1ps
module xa_src_pick #(
  parameter int W     = 9,
  parameter int NPORT = 4
) (
  input  logic [W-1:0]       x_in,
  input  logic [W-1:0]       y_in,
  input  logic               split,
  output logic [NPORT*W-1:0] src_flat
);
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    if (p % 2 == 1) begin : g_odd
      assign src_flat[p*W +: W] = split ? y_in : x_in;
    end else begin : g_even
      assign src_flat[p*W +: W] = x_in;
    end
  end
endmodule

// File: rtl/xa_reg_bank.sv
`timescale 1ns/1ps
module xa_reg_bank #(
  parameter int W     = 9,
  parameter int NPORT = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NPORT-1:0]   ld_en,
  input  logic [NPORT*W-1:0] d_flat,
  output logic [NPORT*W-1:0] q_flat
);
  for (genvar p = 0; p < NPORT; p++) begin : g_reg
    logic [W-1:0] q_r;
    always_ff @(posedge clk) begin
      if (rst)
        q_r <= '0;
      else if (ld_en[p])
        q_r <= d_flat[p*W +: W];
    end
    assign q_flat[p*W +: W] = q_r;
  end
endmodule

// File: rtl/xa_port_mux.sv
`timescale 1ns/1ps
module xa_port_mux
  import xa_route_pkg::*;
#(
  parameter int W     = 9,
  parameter int NPORT = 4
) (
  input  logic [1:0]         path_sel,
  input  logic [NPORT*W-1:0] ir_flat,
  input  logic [NPORT*W-1:0] q_flat,
  input  logic [NPORT*W-1:0] thru_flat,
  output logic [NPORT*W-1:0] port_out
);
  path_sel_e sel_e;
  assign sel_e = path_sel_e'(path_sel);

  for (genvar p = 0; p < NPORT; p++) begin : g_mux
    logic [W-1:0] v;
    always_comb begin
      case (sel_e)
        SEL_READBACK: v = ir_flat[p*W +: W];
        SEL_HELD:     v = q_flat[p*W +: W];
        SEL_BCAST,
        SEL_SPLIT:    v = thru_flat[p*W +: W];
        default:      v = '0;
      endcase
    end
    assign port_out[p*W +: W] = v;
  end
endmodule

// File: rtl/xa_route_top.sv
`timescale 1ns/1ps
module xa_route_top
  import xa_route_pkg::*;
#(
  parameter int W     = 9,
  parameter int NPORT = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [W-1:0]       x_in,
  input  logic [W-1:0]       y_in,
  input  logic [NPORT*W-1:0] ir_flat,
  input  logic [NPORT-1:0]   ld_en,
  input  logic               word_mode,
  input  logic [1:0]         path_sel,
  output logic [NPORT*W-1:0] port_out
);
  localparam int BUSW = NPORT * W;

  logic [BUSW-1:0] load_src;
  logic [BUSW-1:0] thru_src;
  logic [BUSW-1:0] q_flat;
  logic            thru_split;

  assign thru_split = (path_sel == SEL_SPLIT);

  xa_src_pick #(.W(W), .NPORT(NPORT)) u_load_pick (
    .x_in(x_in), .y_in(y_in), .split(word_mode), .src_flat(load_src)
  );

  xa_src_pick #(.W(W), .NPORT(NPORT)) u_thru_pick (
    .x_in(x_in), .y_in(y_in), .split(thru_split), .src_flat(thru_src)
  );

  xa_reg_bank #(.W(W), .NPORT(NPORT)) u_regs (
    .clk(clk), .rst(rst), .ld_en(ld_en), .d_flat(load_src), .q_flat(q_flat)
  );

  xa_port_mux #(.W(W), .NPORT(NPORT)) u_mux (
    .path_sel(path_sel), .ir_flat(ir_flat), .q_flat(q_flat),
    .thru_flat(thru_src), .port_out(port_out)
  );
endmodule

// File: rtl/xa_route_chk.sv
`timescale 1ns/1ps
module xa_route_chk #(
  parameter int W     = 9,
  parameter int NPORT = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [W-1:0]       x_in,
  input logic [W-1:0]       y_in,
  input logic [NPORT*W-1:0] ir_flat,
  input logic [NPORT-1:0]   ld_en,
  input logic               word_mode,
  input logic [1:0]         path_sel,
  input logic [NPORT*W-1:0] q_flat,
  input logic [NPORT*W-1:0] port_out
);
  for (genvar p = 0; p < NPORT; p++) begin : g_chk
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      !ld_en[p] |=> $stable(q_flat[p*W +: W])); // R2

    AST_READBACK: assert property (@(posedge clk) disable iff (rst)
      (path_sel == 2'b00) |-> (port_out[p*W +: W] == ir_flat[p*W +: W])); // R6

    AST_HELD_OUT: assert property (@(posedge clk) disable iff (rst)
      (path_sel == 2'b01) |-> (port_out[p*W +: W] == q_flat[p*W +: W])); // R7

    AST_BCAST_OUT: assert property (@(posedge clk) disable iff (rst)
      (path_sel == 2'b10) |-> (port_out[p*W +: W] == x_in)); // R8

    if (p % 2 == 1) begin : g_odd
      AST_LOAD_NARROW: assert property (@(posedge clk) disable iff (rst)
        (ld_en[p] && !word_mode) |=> (q_flat[p*W +: W] == $past(x_in))); // R3

      AST_LOAD_WIDE: assert property (@(posedge clk) disable iff (rst)
        (ld_en[p] && word_mode) |=> (q_flat[p*W +: W] == $past(y_in))); // R4

      AST_SPLIT_OUT: assert property (@(posedge clk) disable iff (rst)
        (path_sel == 2'b11) |-> (port_out[p*W +: W] == y_in)); // R9
    end else begin : g_even
      AST_LOAD_X: assert property (@(posedge clk) disable iff (rst)
        ld_en[p] |=> (q_flat[p*W +: W] == $past(x_in))); // R4

      AST_SPLIT_OUT: assert property (@(posedge clk) disable iff (rst)
        (path_sel == 2'b11) |-> (port_out[p*W +: W] == x_in)); // R9
    end
  end
endmodule

bind xa_route_top xa_route_chk #(.W(W), .NPORT(NPORT)) u_chk (
  .clk(clk), .rst(rst), .x_in(x_in), .y_in(y_in), .ir_flat(ir_flat),
  .ld_en(ld_en), .word_mode(word_mode), .path_sel(path_sel),
  .q_flat(q_flat), .port_out(port_out)
);

// File: tb/sim_xa_route_top.sv
`timescale 1ns/1ps
module sim_xa_route_top;
  localparam int W = 9;
  localparam int NPORT = 4;
  localparam int NVEC = 8;

  // vector: {word_mode, ld_en[3:0], x[8:0], y[8:0]}
  localparam logic [22:0] VEC [NVEC] = '{
    {1'b0, 4'b1111, 9'h0A5, 9'h15A},
    {1'b1, 4'b1111, 9'h123, 9'h0DE},
    {1'b0, 4'b0101, 9'h1FF, 9'h000},
    {1'b1, 4'b1010, 9'h055, 9'h1AA},
    {1'b1, 4'b0011, 9'h10F, 9'h0F1},
    {1'b0, 4'b1000, 9'h001, 9'h100},
    {1'b1, 4'b1100, 9'h18C, 9'h073},
    {1'b0, 4'b0000, 9'h0CC, 9'h133}
  };

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [W-1:0]       x_in = '0;
  logic [W-1:0]       y_in = '0;
  logic [NPORT*W-1:0] ir_flat = '0;
  logic [NPORT-1:0]   ld_en = '0;
  logic               word_mode = 1'b0;
  logic [1:0]         path_sel = 2'b01;
  logic [NPORT*W-1:0] port_out;

  logic [W-1:0] mreg [NPORT];
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  xa_route_top #(.W(W), .NPORT(NPORT)) u0 (
    .clk(clk), .rst(rst), .x_in(x_in), .y_in(y_in), .ir_flat(ir_flat),
    .ld_en(ld_en), .word_mode(word_mode), .path_sel(path_sel),
    .port_out(port_out)
  );

  task automatic chk(input string req, input int p, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s port %0d: got %h expected %h", req, p, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pout(input int p);
    return port_out[p*W +: W];
  endfunction

  // apply a load at the falling edge, clock it, update model
  task automatic do_load(input logic wm, input logic [NPORT-1:0] en,
                         input logic [W-1:0] xv, input logic [W-1:0] yv);
    word_mode = wm; ld_en = en; x_in = xv; y_in = yv;
    @(posedge clk);
    @(negedge clk);
    ld_en = '0;
    for (int p = 0; p < NPORT; p++)
      if (en[p]) mreg[p] = (wm && (p % 2 == 1)) ? yv : xv;
  endtask

  task automatic check_regs(input string req);
    path_sel = 2'b01;
    #1;
    for (int p = 0; p < NPORT; p++) chk(req, p, pout(p), mreg[p]);
  endtask

  initial begin
    for (int p = 0; p < NPORT; p++) mreg[p] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state, registers cleared
    check_regs("R1");

    // table walk: loads in both word modes plus every select
    for (int v = 0; v < NVEC; v++) begin
      logic [22:0] e;
      e = VEC[v];
      path_sel = 2'b01;
      do_load(e[22], e[21:18], e[17:9], e[8:0]);
      check_regs(e[22] ? "R4" : "R3");
      for (int p = 0; p < NPORT; p++)
        ir_flat[p*W +: W] = e[17:9] ^ W'(p * 37 + v);
      path_sel = 2'b00;
      #1;
      for (int p = 0; p < NPORT; p++)
        chk("R6", p, pout(p), e[17:9] ^ W'(p * 37 + v));
      path_sel = 2'b10;
      #1;
      for (int p = 0; p < NPORT; p++) chk("R8", p, pout(p), e[17:9]);
      path_sel = 2'b11;
      #1;
      for (int p = 0; p < NPORT; p++)
        chk("R9", p, pout(p), (p % 2 == 1) ? e[8:0] : e[17:9]);
      path_sel = 2'b01;
      #1;
      for (int p = 0; p < NPORT; p++) chk("R7", p, pout(p), mreg[p]);
    end

    // R2: enables low, inputs change, registers hold
    x_in = 9'h1E1; y_in = 9'h02E;
    @(posedge clk);
    @(negedge clk);
    check_regs("R2");

    // R5: only port 1 loads, wide mode
    do_load(1'b1, 4'b0010, 9'h0B0, 9'h1C3);
    check_regs("R5");

    // R10: load while the split pass-through is selected
    path_sel = 2'b11;
    word_mode = 1'b0; ld_en = 4'b1111; x_in = 9'h147; y_in = 9'h0B8;
    #1;
    for (int p = 0; p < NPORT; p++)
      chk("R10", p, pout(p), (p % 2 == 1) ? 9'h0B8 : 9'h147);
    @(posedge clk);
    @(negedge clk);
    ld_en = '0;
    for (int p = 0; p < NPORT; p++) mreg[p] = 9'h147;
    check_regs("R10");

    // R10 with broadcast select in wide mode
    path_sel = 2'b10;
    word_mode = 1'b1; ld_en = 4'b0110; x_in = 9'h00F; y_in = 9'h1F0;
    @(posedge clk);
    @(negedge clk);
    ld_en = '0;
    mreg[1] = 9'h1F0; mreg[2] = 9'h00F;
    check_regs("R10");

    // R1: reset after traffic clears all registers
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int p = 0; p < NPORT; p++) mreg[p] = '0;
    check_regs("R1");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule